// File: doc/BRIEF.md
# Interrupt Level Priority Resolver

This block sits between a set of peripheral interrupt lines and a processor core. Each line has a fixed level from 1 to 7 and a fixed rank inside that level. Every cycle the block picks the most urgent pending request and presents the level and vector number of that request to the core. The level is 0 when nothing is pending. Level 7 is the non-maskable tier. Level 6 is the highest maskable tier.

Software can tune the ordering through a small register port. Two promotion slots can each lift one chosen request into the two best positions of level 6, and the request keeps its own vector. A force register raises a synthetic request at any level, and each level has its own vector for that request. The acknowledge handshake and the core's mask comparison are not part of this block.

Top module: `intc_level_resolver`

## Requirements
- R1: A synchronous active-low reset clears both promotion slots, the force register, `cpu_lvl` and `cpu_vec` to 0.
- R2: `cpu_lvl` and `cpu_vec` are registered. They show the outcome of the request and register state one clock edge after that state is present. When nothing is pending, both outputs are 0.
- R3: Source s (1..28, on `irq_req[s-1]`) has native level 7 - (s-1)/4 and vector 64 + s. A higher level always wins. Within a level, the lower source number wins.
- R4: Register address 0 is the upper promotion slot. When it holds a source number s in 5..28 and that request is pending, the request is reported at level 6 ahead of every other level-6 request, with vector 64 + s.
- R5: Register address 1 is the lower promotion slot. A request it names is reported at level 6, below the upper slot and above every native level-6 request, with its own vector.
- R6: A slot value of 0, a value naming a level-7 source (1..4), or a value above 28 has no effect on the outputs.
- R7: When both slots name the same source, only the upper slot acts. The source is then reported once at level 6, and the lower slot does not hide any other request.
- R8: Register address 2 holds force bits, with bit n-1 requesting level n (n = 1..7). A forced request at level n reports vector 56 + n. It ranks below every peripheral request at that level, including promoted ones. Clearing the bit withdraws the request.
- R9: Bit 7 of the force register always reads 0, and writing it has no effect on the outputs.
- R10: `reg_rdata` returns the addressed register zero-extended and combinationally. Address 3 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_req | input | 28 | Peripheral request lines, bit s-1 is source s |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address for read and write |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data |
| cpu_lvl | output | 3 | Winning level, 0 when idle |
| cpu_vec | output | 8 | Vector number of the winning request |

## Verification
The bench aims at the places where ordering can go wrong. A promoted request must beat native level-6 traffic and still lose to level 7. A design that rewrote the vector, or that compared the two slots the wrong way round, would report the wrong number. Selecting a level-7 source in a slot is tested with that source alone, so a design that demoted it would report level 6 instead of 7. Same-source slots, forced requests that tie with real ones, and a write to the reserved force bit are checked at the outputs: a wrong design would show a forced vector where a peripheral should win, or a spurious level.

// File: rtl/intc_pkg.sv
// Shared constants and types for the interrupt level resolver.
// Assumes seven interrupt levels, with level 6 as the promotion target.
package intc_pkg;
    localparam int NUM_LVL   = 7;
    localparam int PROMO_LVL = 6;

    typedef logic [2:0] lvl_t;

    typedef enum logic [1:0] {
        ADDR_SLOT_HI = 2'd0,
        ADDR_SLOT_LO = 2'd1,
        ADDR_FORCE   = 2'd2,
        ADDR_NONE    = 2'd3
    } reg_addr_e;
endpackage

// File: rtl/intc_regs.sv
// Software register file: two promotion slots and the per-level force bits.
// Assumes DATA_W >= NUM_LVL + 1 and DATA_W >= IDX_W. The read path is combinational.
module intc_regs
    import intc_pkg::*;
#(
    parameter int IDX_W  = 5,
    parameter int DATA_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr,
    input  logic [1:0]         addr,
    input  logic [DATA_W-1:0]  wdata,
    output logic [DATA_W-1:0]  rdata,
    output logic [IDX_W-1:0]   slot_hi,
    output logic [IDX_W-1:0]   slot_lo,
    output logic [NUM_LVL-1:0] force_lvl
);
    logic unused_wbits;
    assign unused_wbits = ^wdata;

    // Store writes; the reserved top force bit is never kept.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_hi   <= '0;
            slot_lo   <= '0;
            force_lvl <= '0;
        end else if (wr) begin
            case (reg_addr_e'(addr))
                ADDR_SLOT_HI: slot_hi   <= wdata[IDX_W-1:0];
                ADDR_SLOT_LO: slot_lo   <= wdata[IDX_W-1:0];
                ADDR_FORCE:   force_lvl <= wdata[NUM_LVL-1:0];
                default:      ;
            endcase
        end
    end

    // Return the addressed register, zero-extended.
    always_comb begin
        case (reg_addr_e'(addr))
            ADDR_SLOT_HI: rdata = DATA_W'(slot_hi);
            ADDR_SLOT_LO: rdata = DATA_W'(slot_lo);
            ADDR_FORCE:   rdata = DATA_W'(force_lvl);
            default:      rdata = '0;
        endcase
    end
endmodule

// File: rtl/intc_remap.sv
// Promotion slot decode: decides which slot is live and masks promoted
// sources out of their native level. Assumes sources 1..PER_LVL are level 7.
module intc_remap #(
    parameter int NUM_SRC = 28,
    parameter int PER_LVL = 4,
    parameter int IDX_W   = 5
) (
    input  logic [NUM_SRC-1:0] req,
    input  logic [IDX_W-1:0]   slot_hi,
    input  logic [IDX_W-1:0]   slot_lo,
    output logic [NUM_SRC-1:0] eff_req,
    output logic               hi_hit,
    output logic               lo_hit
);
    localparam int WIDE = 2 ** IDX_W;

    logic            hi_ok;
    logic            lo_ok;
    logic [WIDE-1:0] req_wide;

    // A slot is live only for a maskable source that exists; the upper slot wins a tie.
    always_comb begin
        hi_ok = (int'(slot_hi) > PER_LVL) && (int'(slot_hi) <= NUM_SRC);
        lo_ok = (int'(slot_lo) > PER_LVL) && (int'(slot_lo) <= NUM_SRC)
                && !(hi_ok && (slot_lo == slot_hi));
    end

    // Bit s of the wide vector is source s; bit 0 stays empty.
    always_comb begin
        req_wide              = '0;
        req_wide[NUM_SRC:1]   = req;
        hi_hit                = hi_ok && req_wide[slot_hi];
        lo_hit                = lo_ok && req_wide[slot_lo];
    end

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_mask
        // Remove a promoted source from its native level.
        assign eff_req[i] = req[i]
                            && !(hi_ok && (int'(slot_hi) == i + 1))
                            && !(lo_ok && (int'(slot_lo) == i + 1));
    end
endmodule

// File: rtl/intc_arbiter.sv
// Priority resolution: per-level encoder, then a level scan that merges
// promoted and forced requests. Assumes sources are grouped PER_LVL per level,
// with level 7 first and the lowest number winning inside a level.
module intc_arbiter
    import intc_pkg::*;
#(
    parameter int NUM_SRC      = 28,
    parameter int PER_LVL      = 4,
    parameter int IDX_W        = 5,
    parameter int VEC_W        = 8,
    parameter int VEC_BASE     = 64,
    parameter int FRC_VEC_BASE = 56
) (
    input  logic [NUM_SRC-1:0] eff_req,
    input  logic [NUM_LVL-1:0] force_lvl,
    input  logic               hi_hit,
    input  logic               lo_hit,
    input  logic [IDX_W-1:0]   slot_hi,
    input  logic [IDX_W-1:0]   slot_lo,
    output lvl_t               win_lvl,
    output logic [VEC_W-1:0]   win_vec
);
    localparam int TOT = NUM_LVL * PER_LVL;

    logic [TOT-1:0]   pad;
    logic [NUM_LVL:1] nat_hit;
    logic [IDX_W-1:0] nat_src [NUM_LVL:1];

    assign pad = TOT'(eff_req);

    function automatic logic [VEC_W-1:0] src_vec(input logic [IDX_W-1:0] s);
        return VEC_W'(VEC_BASE + int'(s));
    endfunction

    for (genvar lv = 1; lv <= NUM_LVL; lv++) begin : g_lvl
        localparam int FIRST = (NUM_LVL - lv) * PER_LVL;
        logic             hit;
        logic [IDX_W-1:0] src;

        // Find the lowest-numbered pending source of this level.
        always_comb begin
            hit = 1'b0;
            src = '0;
            for (int k = PER_LVL - 1; k >= 0; k--) begin
                if (pad[FIRST + k]) begin
                    hit = 1'b1;
                    src = IDX_W'(FIRST + k + 1);
                end
            end
        end

        assign nat_hit[lv] = hit;
        assign nat_src[lv] = src;
    end

    // Scan levels upward so the highest pending level is the last one taken.
    always_comb begin
        win_lvl = '0;
        win_vec = '0;
        for (int lv = 1; lv <= NUM_LVL; lv++) begin
            if (lv == PROMO_LVL && (hi_hit || lo_hit)) begin
                win_lvl = lvl_t'(lv);
                win_vec = hi_hit ? src_vec(slot_hi) : src_vec(slot_lo);
            end else if (nat_hit[lv]) begin
                win_lvl = lvl_t'(lv);
                win_vec = src_vec(nat_src[lv]);
            end else if (force_lvl[lv-1]) begin
                win_lvl = lvl_t'(lv);
                win_vec = VEC_W'(FRC_VEC_BASE + lv);
            end
        end
    end
endmodule

// File: rtl/intc_level_resolver.sv
// Top of the interrupt level resolver: register file, promotion decode,
// arbitration and the output stage. Assumes NUM_SRC <= 7 * PER_LVL.
// The outputs are registered, so they lag the inputs by one clock.
module intc_level_resolver
    import intc_pkg::*;
#(
    parameter int NUM_SRC      = 28,
    parameter int PER_LVL      = 4,
    parameter int DATA_W       = 8,
    parameter int VEC_W        = 8,
    parameter int VEC_BASE     = 64,
    parameter int FRC_VEC_BASE = 56,
    localparam int IDX_W       = $clog2(NUM_SRC + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] irq_req,
    input  logic               reg_wr,
    input  logic [1:0]         reg_addr,
    input  logic [DATA_W-1:0]  reg_wdata,
    output logic [DATA_W-1:0]  reg_rdata,
    output logic [2:0]         cpu_lvl,
    output logic [VEC_W-1:0]   cpu_vec
);
    logic [IDX_W-1:0]   slot_hi;
    logic [IDX_W-1:0]   slot_lo;
    logic [NUM_LVL-1:0] force_lvl;
    logic [NUM_SRC-1:0] eff_req;
    logic               hi_hit;
    logic               lo_hit;
    lvl_t               win_lvl;
    logic [VEC_W-1:0]   win_vec;

    intc_regs #(.IDX_W(IDX_W), .DATA_W(DATA_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr),
        .wdata(reg_wdata), .rdata(reg_rdata),
        .slot_hi(slot_hi), .slot_lo(slot_lo), .force_lvl(force_lvl)
    );

    intc_remap #(.NUM_SRC(NUM_SRC), .PER_LVL(PER_LVL), .IDX_W(IDX_W)) u_remap (
        .req(irq_req), .slot_hi(slot_hi), .slot_lo(slot_lo),
        .eff_req(eff_req), .hi_hit(hi_hit), .lo_hit(lo_hit)
    );

    intc_arbiter #(
        .NUM_SRC(NUM_SRC), .PER_LVL(PER_LVL), .IDX_W(IDX_W), .VEC_W(VEC_W),
        .VEC_BASE(VEC_BASE), .FRC_VEC_BASE(FRC_VEC_BASE)
    ) u_arb (
        .eff_req(eff_req), .force_lvl(force_lvl), .hi_hit(hi_hit), .lo_hit(lo_hit),
        .slot_hi(slot_hi), .slot_lo(slot_lo), .win_lvl(win_lvl), .win_vec(win_vec)
    );

    // Register the winner toward the core.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cpu_lvl <= '0;
            cpu_vec <= '0;
        end else begin
            cpu_lvl <= win_lvl;
            cpu_vec <= win_vec;
        end
    end
endmodule

// File: rtl/intc_level_resolver_chk.sv
// Temporal checks on the resolver, bound to the top module.
// Assumes the default source grouping (level 7 holds sources 1..PER_LVL).
module intc_level_resolver_chk #(
    parameter int NUM_SRC  = 28,
    parameter int PER_LVL  = 4,
    parameter int IDX_W    = 5,
    parameter int DATA_W   = 8,
    parameter int VEC_W    = 8,
    parameter int VEC_BASE = 64
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_SRC-1:0] irq_req,
    input logic [1:0]         reg_addr,
    input logic [DATA_W-1:0]  reg_rdata,
    input logic [2:0]         cpu_lvl,
    input logic [VEC_W-1:0]   cpu_vec,
    input logic [6:0]         force_q,
    input logic [IDX_W-1:0]   slot_hi_q,
    input logic [IDX_W-1:0]   slot_lo_q
);
    logic [2**IDX_W-1:0] req_wide;
    logic                hi_live;

    // Observe whether the upper slot names a pending maskable source.
    always_comb begin
        req_wide            = '0;
        req_wide[NUM_SRC:1] = irq_req;
        hi_live = (int'(slot_hi_q) > PER_LVL) && (int'(slot_hi_q) <= NUM_SRC)
                  && req_wide[slot_hi_q];
    end

    p_reset_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (force_q == '0 && slot_hi_q == '0 && slot_lo_q == '0 && cpu_lvl == 3'd0));

    p_idle_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(irq_req) == '0 && $past(force_q) == '0)
        |-> (cpu_lvl == 3'd0 && cpu_vec == '0));

    p_lvl_vec_pair_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_lvl == 3'd0) |-> (cpu_vec == '0));

    p_top_source_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(irq_req[0]))
        |-> (cpu_lvl == 3'd7 && cpu_vec == VEC_W'(VEC_BASE + 1)));

    p_slot_hi_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(hi_live) && $past(irq_req[PER_LVL-1:0]) == '0 && !$past(force_q[6]))
        |-> (cpu_lvl == 3'd6 && cpu_vec == VEC_W'(VEC_BASE + int'($past(slot_hi_q)))));

    p_force_top_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(force_q[6])) |-> (cpu_lvl == 3'd7));

    // Read-side checks on the register port.
    always @(posedge clk) begin
        if (rst_n && reg_addr == 2'd2) begin
            p_rsvd_bit_r9: assert (reg_rdata[7] == 1'b0);
        end
        if (rst_n && reg_addr == 2'd3) begin
            p_hole_read_r10: assert (reg_rdata == '0);
        end
    end
endmodule

bind intc_level_resolver intc_level_resolver_chk #(
    .NUM_SRC(NUM_SRC), .PER_LVL(PER_LVL), .IDX_W(IDX_W),
    .DATA_W(DATA_W), .VEC_W(VEC_W), .VEC_BASE(VEC_BASE)
) u_chk (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .reg_addr(reg_addr),
    .reg_rdata(reg_rdata), .cpu_lvl(cpu_lvl), .cpu_vec(cpu_vec),
    .force_q(force_lvl), .slot_hi_q(slot_hi), .slot_lo_q(slot_lo)
);

// File: tb/intc_level_resolver_test.sv
// Bench for the resolver: a vector table walked by one loop, then directed tests.
module intc_level_resolver_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [27:0] irq_req = '0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic [7:0]  reg_wdata = '0;
    logic [7:0]  reg_rdata;
    logic [2:0]  cpu_lvl;
    logic [7:0]  cpu_vec;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    intc_level_resolver uut (
        .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .cpu_lvl(cpu_lvl), .cpu_vec(cpu_vec)
    );

    // Row: {tag[4], req[28], slot_hi[5], slot_lo[5], force[7], lvl[3], vec[8]}
    localparam int NROW = 21;
    localparam logic [59:0] TBL [NROW] = '{
        {4'd2, 28'h0000000, 5'd0,  5'd0,  7'h00, 3'd0, 8'd0},   // R2 idle
        {4'd3, 28'h8000000, 5'd0,  5'd0,  7'h00, 3'd1, 8'd92},  // R3 lowest level alone
        {4'd3, 28'h8080000, 5'd0,  5'd0,  7'h00, 3'd3, 8'd84},  // R3 higher level wins
        {4'd3, 28'h0060000, 5'd0,  5'd0,  7'h00, 3'd3, 8'd82},  // R3 lower number wins
        {4'd3, 28'h0000106, 5'd0,  5'd0,  7'h00, 3'd7, 8'd66},  // R3 level 7
        {4'd4, 28'h0000210, 5'd10, 5'd0,  7'h00, 3'd6, 8'd74},  // R4 promoted beats native 6
        {4'd4, 28'h0000211, 5'd10, 5'd0,  7'h00, 3'd7, 8'd65},  // R4 level 7 still beats it
        {4'd5, 28'h0000810, 5'd0,  5'd12, 7'h00, 3'd6, 8'd76},  // R5 lower slot beats native 6
        {4'd4, 28'h0080810, 5'd20, 5'd12, 7'h00, 3'd6, 8'd84},  // R4 upper beats lower
        {4'd5, 28'h0000810, 5'd20, 5'd12, 7'h00, 3'd6, 8'd76},  // R5 upper idle
        {4'd6, 28'h0000002, 5'd2,  5'd0,  7'h00, 3'd7, 8'd66},  // R6 level-7 source not demoted
        {4'd6, 28'h0000100, 5'd29, 5'd0,  7'h00, 3'd5, 8'd73},  // R6 out-of-range slot
        {4'd7, 28'h0000A00, 5'd10, 5'd10, 7'h00, 3'd6, 8'd74},  // R7 same source in both
        {4'd7, 28'h0000010, 5'd10, 5'd10, 7'h00, 3'd6, 8'd69},  // R7 lower slot hides nothing
        {4'd8, 28'h0000000, 5'd0,  5'd0,  7'h04, 3'd3, 8'd59},  // R8 forced level 3
        {4'd8, 28'h0080000, 5'd0,  5'd0,  7'h04, 3'd3, 8'd84},  // R8 peripheral beats forced
        {4'd8, 28'h8000000, 5'd0,  5'd0,  7'h10, 3'd5, 8'd61},  // R8 forced above peripheral
        {4'd8, 28'h0000010, 5'd0,  5'd0,  7'h40, 3'd7, 8'd63},  // R8 forced level 7
        {4'd8, 28'h0000800, 5'd0,  5'd12, 7'h20, 3'd6, 8'd76},  // R8 promoted beats forced 6
        {4'd8, 28'h0000000, 5'd0,  5'd0,  7'h7F, 3'd7, 8'd63},  // R8 all forced
        {4'd2, 28'h0000000, 5'd0,  5'd0,  7'h00, 3'd0, 8'd0}    // R2 withdrawn
    };

    task automatic check(input int tag, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL R%0d %s: got %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output int v);
        reg_addr = a;
        #1;
        v = int'(reg_rdata);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL R2 watchdog: got timeout expected completion");
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        int v;
        logic [59:0] row;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        check(1, "reset lvl", int'(cpu_lvl), 0);
        check(1, "reset vec", int'(cpu_vec), 0);
        rd(2'd0, v); check(1, "reset slot hi", v, 0);
        rd(2'd1, v); check(1, "reset slot lo", v, 0);
        rd(2'd2, v); check(1, "reset force", v, 0);

        for (int i = 0; i < NROW; i++) begin
            row = TBL[i];
            wr(2'd0, 8'(row[27:23]));
            wr(2'd1, 8'(row[22:18]));
            wr(2'd2, 8'(row[17:11]));
            irq_req = row[55:28];
            @(negedge clk);
            check(int'(row[59:56]), $sformatf("row %0d lvl", i), int'(cpu_lvl), int'(row[10:8]));
            check(int'(row[59:56]), $sformatf("row %0d vec", i), int'(cpu_vec), int'(row[7:0]));
        end

        // R2 output waits for the clock edge
        irq_req = 28'h8000000;
        #1;
        check(2, "lvl before edge", int'(cpu_lvl), 0);
        @(negedge clk);
        check(2, "lvl after edge", int'(cpu_lvl), 1);
        irq_req = '0;
        @(negedge clk);

        // R10 readback and unused address
        wr(2'd0, 8'd29);
        rd(2'd0, v); check(10, "slot hi readback", v, 29);
        wr(2'd1, 8'd7);
        rd(2'd1, v); check(10, "slot lo readback", v, 7);
        rd(2'd3, v); check(10, "address 3", v, 0);
        wr(2'd0, 8'd0);
        wr(2'd1, 8'd0);

        // R9 reserved force bit
        wr(2'd2, 8'hFF);
        rd(2'd2, v); check(9, "force readback", v, 8'h7F);
        wr(2'd2, 8'h80);
        rd(2'd2, v); check(9, "reserved only readback", v, 0);
        @(negedge clk);
        check(9, "reserved write lvl", int'(cpu_lvl), 0);
        check(9, "reserved write vec", int'(cpu_vec), 0);

        // R1 reset in the middle of activity
        wr(2'd2, 8'h08);
        wr(2'd0, 8'd10);
        irq_req = 28'h0000200;
        @(negedge clk);
        check(6, "pre-reset lvl", int'(cpu_lvl), 6);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        irq_req = '0;
        rst_n = 1'b1;
        check(1, "mid reset lvl", int'(cpu_lvl), 0);
        rd(2'd2, v); check(1, "mid reset force", v, 0);
        rd(2'd0, v); check(1, "mid reset slot", v, 0);
        @(negedge clk);
        check(1, "after reset vec", int'(cpu_vec), 0);

        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule